// File: doc/BRIEF.md
# DDR Command Spacing Checker

The block watches the command stream of a registered DDR SDRAM interface and counts clock cycles between commands. It flags any command issued sooner than the minimum spacing rules allow. It receives the decoded command with its rank, bank and auto-precharge flag, the burst-length and CAS-latency settings, and the core timing values in picoseconds together with the clock period in picoseconds. It converts each timing value to whole clocks by rounding up. It keeps saturating cycle counters per bank and per rank. From these it evaluates thirteen spacing rules for the command of the current cycle.

The first rule broken is recorded as a sticky flag plus a code that names the rule. The record stays until a clear input is pulsed. It is meant to sit beside a memory controller in simulation or silicon as a protocol monitor. The turnaround rules are already adjusted for the extra clock of command latency that a registered module adds.

Top module: `ddr_cmd_spacing_chk`

## Requirements
- R1: Each timing value converts to clocks as ceil(t_ps / tck_ps), and each term of a summed window is rounded on its own before the sum. Example at 6 ns: write recovery 15 ns gives 3, not 2.5.
- R2: A read (cmd 2) or write (cmd 3) to a bank fewer than ceil(tRCD) cycles after an activate (cmd 1) to that bank gives code 1.
- R3: A precharge (cmd 4) fewer than ceil(tRAS) cycles after an activate to the bank gives code 2. With cmd_ap=1 the precharge covers every bank of the rank, and every bank of that rank is checked.
- R4: An activate to a bank gives code 3 when the bank is not yet ready. After a precharge the bank needs ceil(tRP) cycles. After a read with auto-precharge it needs BL/2 + ceil(tRP). After a write with auto-precharge it needs 2 + BL/2 + ceil(tWR) + ceil(tRP).
- R5: Two activates to the same bank closer than ceil(tRC) give code 4. Two activates to any banks of one rank closer than ceil(tRRD) give code 5.
- R6: A precharge fewer than 1 + ceil(tWR) + BL/2 cycles after a write to the bank gives code 6. A precharge fewer than BL/2 cycles after a read to the bank gives code 7. bl_sel 0/1/2 selects BL 2/4/8, and 3 is taken as 8.
- R7: Within one rank, a read fewer than 2 + BL/2 cycles after a write gives code 8. A write fewer than L + BL/2 cycles after a read gives code 9, where L is 3 when cl_sel=1 (module CL 3.5) and 2 when cl_sel=0 (module CL 3).
- R8: Any non-NOP command to a rank fewer than 2 cycles after a mode register set (cmd 6) to it gives code 10.
- R9: An activate or refresh (cmd 5) fewer than ceil(tRFC) cycles after a refresh gives code 11. After a self-refresh exit (cmd 7), a non-read command within ceil(tRFC) cycles gives code 12, and a read within 200 cycles gives code 13.
- R10: The first violation sets viol and latches viol_code. Both then hold unchanged until clr is pulsed. A clr in the same cycle as a violating command wins, and nothing is recorded.
- R11: When one command breaks several rules, the lowest code number is recorded.
- R12: Every spacing counter saturates at its maximum (255 by default) and never wraps.
- R13: After reset viol is 0 and viol_code is 0, and all counters start saturated, so no command is flagged for history that has not happened.
- R14: NOP (cmd 0) is checked against no rule and never raises a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clears the recorded violation |
| cmd | input | 3 | Command: 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE, 5 REF, 6 MRS, 7 SRX |
| cmd_rank | input | RANK_W (1) | Target rank |
| cmd_bank | input | BANK_W (2) | Target bank |
| cmd_ap | input | 1 | Auto-precharge on RD/WR, all-bank on PRE |
| bl_sel | input | 2 | Burst length select |
| cl_sel | input | 1 | 1 = module CL 3.5, 0 = module CL 3 |
| tck_ps | input | PS_W (17) | Clock period in ps |
| trcd_ps | input | PS_W | Activate to read/write |
| tras_ps | input | PS_W | Activate to precharge |
| trp_ps | input | PS_W | Precharge period |
| trrd_ps | input | PS_W | Activate to activate, different banks |
| trc_ps | input | PS_W | Activate to activate, same bank |
| trfc_ps | input | PS_W | Refresh cycle |
| twr_ps | input | PS_W | Write recovery |
| viol | output | 1 | Sticky violation flag |
| viol_code | output | 4 | Code of the first rule broken |

## Verification
Each rule is driven as a pair of commands. One pair sits one cycle inside the limit, and a second pair sits exactly on the limit, so an off-by-one in either the counter or the comparison shows up. Pairs aimed at the wrong bank or wrong rank separate per-bank state from rank-wide state. A second timing profile at a 6 ns period exposes rounding that truncates or sums before rounding. Further sequences with two broken rules, a violation followed by another, a clear racing a violation, and a gap longer than the counter range tell apart priority, sticky capture, clear precedence and saturation from wrap-around.

// File: rtl/ddr_spc_pkg.sv
package ddr_spc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6,
    CMD_SRX = 3'd7
  } cmd_e;

  typedef enum logic [3:0] {
    V_NONE = 4'd0,
    V_RCD  = 4'd1,
    V_RAS  = 4'd2,
    V_RP   = 4'd3,
    V_RC   = 4'd4,
    V_RRD  = 4'd5,
    V_WPD  = 4'd6,
    V_RPD  = 4'd7,
    V_WTR  = 4'd8,
    V_RTW  = 4'd9,
    V_MRD  = 4'd10,
    V_RFC  = 4'd11,
    V_XSNR = 4'd12,
    V_XSRD = 4'd13
  } vcode_e;

  localparam int NRULE = 13;

  // R1: round up, each term on its own
  function automatic int unsigned ps_to_clk(input int unsigned t, input int unsigned tck);
    if (tck == 0) return 0;
    return (t + tck - 1) / tck;
  endfunction

  // R6: half the burst length in clocks
  function automatic int unsigned half_burst(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/ddr_spc_cvt.sv
module ddr_spc_cvt
  import ddr_spc_pkg::*;
#(
  parameter int PS_W  = 17,
  parameter int CNT_W = 8
) (
  input  logic [PS_W-1:0]  tck_ps,
  input  logic [PS_W-1:0]  trcd_ps,
  input  logic [PS_W-1:0]  tras_ps,
  input  logic [PS_W-1:0]  trp_ps,
  input  logic [PS_W-1:0]  trrd_ps,
  input  logic [PS_W-1:0]  trc_ps,
  input  logic [PS_W-1:0]  trfc_ps,
  input  logic [PS_W-1:0]  twr_ps,
  input  logic [1:0]       bl_sel,
  input  logic             cl_sel,
  output logic [CNT_W-1:0] n_rcd,
  output logic [CNT_W-1:0] n_ras,
  output logic [CNT_W-1:0] n_rp,
  output logic [CNT_W-1:0] n_rrd,
  output logic [CNT_W-1:0] n_rc,
  output logic [CNT_W-1:0] n_rfc,
  output logic [CNT_W-1:0] n_wpd,
  output logic [CNT_W-1:0] n_rpd,
  output logic [CNT_W-1:0] n_wtr,
  output logic [CNT_W-1:0] n_rtw,
  output logic [CNT_W-1:0] n_dal_rd,
  output logic [CNT_W-1:0] n_dal_wr
);
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  function automatic logic [CNT_W-1:0] clampc(input int unsigned v);
    logic [31:0] t;
    t = v;
    if (v > CNT_MAX) return CNT_W'(CNT_MAX);
    return t[CNT_W-1:0];
  endfunction

  int unsigned tck, c_wr, c_rp, bh, rd_lat;

  always_comb begin
    tck    = int'(tck_ps);
    c_wr   = ps_to_clk(int'(twr_ps), tck);
    c_rp   = ps_to_clk(int'(trp_ps), tck);
    bh     = half_burst(bl_sel);
    rd_lat = cl_sel ? 3 : 2;               // R7: registered module adds one clock
    n_rcd    = clampc(ps_to_clk(int'(trcd_ps), tck));
    n_ras    = clampc(ps_to_clk(int'(tras_ps), tck));
    n_rp     = clampc(c_rp);
    n_rrd    = clampc(ps_to_clk(int'(trrd_ps), tck));
    n_rc     = clampc(ps_to_clk(int'(trc_ps), tck));
    n_rfc    = clampc(ps_to_clk(int'(trfc_ps), tck));
    n_wpd    = clampc(1 + c_wr + bh);
    n_rpd    = clampc(bh);
    n_wtr    = clampc(2 + bh);
    n_rtw    = clampc(rd_lat + bh);
    n_dal_rd = clampc(bh + c_rp);          // R4
    n_dal_wr = clampc(2 + bh + c_wr + c_rp);
  end
endmodule

// File: rtl/ddr_spc_bank.sv
module ddr_spc_bank
  import ddr_spc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             pre_all,
  input  cmd_e             cmd,
  input  logic             ap,
  input  logic [CNT_W-1:0] n_rp,
  input  logic [CNT_W-1:0] n_dal_rd,
  input  logic [CNT_W-1:0] n_dal_wr,
  output logic [CNT_W-1:0] since_act,
  output logic [CNT_W-1:0] since_pre,
  output logic [CNT_W-1:0] since_wr,
  output logic [CNT_W-1:0] since_rd,
  output logic [CNT_W-1:0] act_need
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  // R12: saturating step
  function automatic logic [CNT_W-1:0] up(input logic [CNT_W-1:0] x);
    return (x == CMAX) ? x : x + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= CMAX;
      since_pre <= CMAX;
      since_wr  <= CMAX;
      since_rd  <= CMAX;
      act_need  <= '0;
    end else begin
      since_act <= (hit && cmd == CMD_ACT) ? ONE : up(since_act);
      since_wr  <= (hit && cmd == CMD_WR)  ? ONE : up(since_wr);
      since_rd  <= (hit && cmd == CMD_RD)  ? ONE : up(since_rd);
      if ((hit && cmd == CMD_PRE) || pre_all) begin
        since_pre <= ONE;
        act_need  <= n_rp;
      end else if (hit && ap && cmd == CMD_RD) begin
        since_pre <= ONE;
        act_need  <= n_dal_rd;
      end else if (hit && ap && cmd == CMD_WR) begin
        since_pre <= ONE;
        act_need  <= n_dal_wr;
      end else begin
        since_pre <= up(since_pre);
      end
    end
  end
endmodule

// File: rtl/ddr_spc_rank.sv
module ddr_spc_rank
  import ddr_spc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  cmd_e             cmd,
  output logic [CNT_W-1:0] since_act,
  output logic [CNT_W-1:0] since_rd,
  output logic [CNT_W-1:0] since_wr,
  output logic [CNT_W-1:0] since_mrs,
  output logic [CNT_W-1:0] since_ref,
  output logic [CNT_W-1:0] since_srx
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  function automatic logic [CNT_W-1:0] up(input logic [CNT_W-1:0] x);
    return (x == CMAX) ? x : x + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= CMAX;
      since_rd  <= CMAX;
      since_wr  <= CMAX;
      since_mrs <= CMAX;
      since_ref <= CMAX;
      since_srx <= CMAX;
    end else begin
      since_act <= (hit && cmd == CMD_ACT) ? ONE : up(since_act);
      since_rd  <= (hit && cmd == CMD_RD)  ? ONE : up(since_rd);
      since_wr  <= (hit && cmd == CMD_WR)  ? ONE : up(since_wr);
      since_mrs <= (hit && cmd == CMD_MRS) ? ONE : up(since_mrs);
      since_ref <= (hit && cmd == CMD_REF) ? ONE : up(since_ref);
      since_srx <= (hit && cmd == CMD_SRX) ? ONE : up(since_srx);
    end
  end
endmodule

// File: rtl/ddr_cmd_spacing_chk.sv
module ddr_cmd_spacing_chk
  import ddr_spc_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int NUM_BANKS = 4,
  parameter int PS_W      = 17,
  parameter int CNT_W     = 8,
  parameter int MRD_CLK   = 2,
  parameter int XSRD_CLK  = 200,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [2:0]        cmd,
  input  logic [RANK_W-1:0] cmd_rank,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_ap,
  input  logic [1:0]        bl_sel,
  input  logic              cl_sel,
  input  logic [PS_W-1:0]   tck_ps,
  input  logic [PS_W-1:0]   trcd_ps,
  input  logic [PS_W-1:0]   tras_ps,
  input  logic [PS_W-1:0]   trp_ps,
  input  logic [PS_W-1:0]   trrd_ps,
  input  logic [PS_W-1:0]   trc_ps,
  input  logic [PS_W-1:0]   trfc_ps,
  input  logic [PS_W-1:0]   twr_ps,
  output logic              viol,
  output logic [3:0]        viol_code
);
  localparam int NBT   = NUM_RANKS * NUM_BANKS;
  localparam int IDX_W = RANK_W + BANK_W;
  localparam logic [CNT_W-1:0] N_MRD  = CNT_W'(MRD_CLK);
  localparam logic [CNT_W-1:0] N_XSRD = CNT_W'(XSRD_CLK);

  cmd_e c;
  assign c = cmd_e'(cmd);

  logic [IDX_W-1:0] idx;
  assign idx = {cmd_rank, cmd_bank};

  // converted windows
  logic [CNT_W-1:0] n_rcd, n_ras, n_rp, n_rrd, n_rc, n_rfc;
  logic [CNT_W-1:0] n_wpd, n_rpd, n_wtr, n_rtw, n_dal_rd, n_dal_wr;

  ddr_spc_cvt #(.PS_W(PS_W), .CNT_W(CNT_W)) u_cvt (
    .tck_ps(tck_ps), .trcd_ps(trcd_ps), .tras_ps(tras_ps), .trp_ps(trp_ps),
    .trrd_ps(trrd_ps), .trc_ps(trc_ps), .trfc_ps(trfc_ps), .twr_ps(twr_ps),
    .bl_sel(bl_sel), .cl_sel(cl_sel),
    .n_rcd(n_rcd), .n_ras(n_ras), .n_rp(n_rp), .n_rrd(n_rrd), .n_rc(n_rc),
    .n_rfc(n_rfc), .n_wpd(n_wpd), .n_rpd(n_rpd), .n_wtr(n_wtr), .n_rtw(n_rtw),
    .n_dal_rd(n_dal_rd), .n_dal_wr(n_dal_wr)
  );

  // per-bank state
  logic [CNT_W-1:0] b_act  [NBT];
  logic [CNT_W-1:0] b_pre  [NBT];
  logic [CNT_W-1:0] b_wr   [NBT];
  logic [CNT_W-1:0] b_rd   [NBT];
  logic [CNT_W-1:0] b_need [NBT];

  for (genvar g = 0; g < NBT; g++) begin : g_bank
    logic bank_hit, bank_pre_all;
    assign bank_hit     = (idx == IDX_W'(g));
    assign bank_pre_all = (c == CMD_PRE) && cmd_ap && (cmd_rank == RANK_W'(g / NUM_BANKS));
    ddr_spc_bank #(.CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .hit(bank_hit), .pre_all(bank_pre_all),
      .cmd(c), .ap(cmd_ap), .n_rp(n_rp), .n_dal_rd(n_dal_rd), .n_dal_wr(n_dal_wr),
      .since_act(b_act[g]), .since_pre(b_pre[g]), .since_wr(b_wr[g]),
      .since_rd(b_rd[g]), .act_need(b_need[g])
    );
  end

  // rank-wide state
  logic [CNT_W-1:0] r_act [NUM_RANKS];
  logic [CNT_W-1:0] r_rd  [NUM_RANKS];
  logic [CNT_W-1:0] r_wr  [NUM_RANKS];
  logic [CNT_W-1:0] r_mrs [NUM_RANKS];
  logic [CNT_W-1:0] r_ref [NUM_RANKS];
  logic [CNT_W-1:0] r_srx [NUM_RANKS];

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic rank_hit;
    assign rank_hit = (cmd_rank == RANK_W'(r));
    ddr_spc_rank #(.CNT_W(CNT_W)) u_rank (
      .clk(clk), .rst_n(rst_n), .hit(rank_hit), .cmd(c),
      .since_act(r_act[r]), .since_rd(r_rd[r]), .since_wr(r_wr[r]),
      .since_mrs(r_mrs[r]), .since_ref(r_ref[r]), .since_srx(r_srx[r])
    );
  end

  // rule evaluation, brought out as named wires
  logic [NRULE:1] rule_hit;
  logic           any_hit;
  vcode_e         code_nxt;

  always_comb begin
    rule_hit = '0;
    case (c)
      CMD_ACT: begin
        rule_hit[V_RP]  = b_pre[idx] < b_need[idx];        // R4
        rule_hit[V_RC]  = b_act[idx] < n_rc;               // R5
        rule_hit[V_RRD] = r_act[cmd_rank] < n_rrd;         // R5
        rule_hit[V_RFC] = r_ref[cmd_rank] < n_rfc;         // R9
      end
      CMD_RD: begin
        rule_hit[V_RCD] = b_act[idx] < n_rcd;              // R2
        rule_hit[V_WTR] = r_wr[cmd_rank] < n_wtr;          // R7
      end
      CMD_WR: begin
        rule_hit[V_RCD] = b_act[idx] < n_rcd;              // R2
        rule_hit[V_RTW] = r_rd[cmd_rank] < n_rtw;          // R7
      end
      CMD_PRE: begin
        for (int j = 0; j < NUM_BANKS; j++) begin
          if (cmd_ap || cmd_bank == BANK_W'(j)) begin      // R3 all-bank form
            if (b_act[{cmd_rank, BANK_W'(j)}] < n_ras) rule_hit[V_RAS] = 1'b1;
            if (b_wr[{cmd_rank, BANK_W'(j)}]  < n_wpd) rule_hit[V_WPD] = 1'b1;  // R6
            if (b_rd[{cmd_rank, BANK_W'(j)}]  < n_rpd) rule_hit[V_RPD] = 1'b1;
          end
        end
      end
      CMD_REF: rule_hit[V_RFC] = r_ref[cmd_rank] < n_rfc;  // R9
      default: ;
    endcase
    if (c != CMD_NOP) begin                                // R14
      rule_hit[V_MRD] = r_mrs[cmd_rank] < N_MRD;           // R8
      if (c == CMD_RD) rule_hit[V_XSRD] = r_srx[cmd_rank] < N_XSRD;
      else             rule_hit[V_XSNR] = r_srx[cmd_rank] < n_rfc;
    end
  end

  assign any_hit = |rule_hit;

  // R11: lowest code wins
  always_comb begin
    code_nxt = V_NONE;
    for (int i = NRULE; i >= 1; i--)
      if (rule_hit[i]) code_nxt = vcode_e'(4'(i));
  end

  // R10: first-violation capture, clear wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol      <= 1'b0;
      viol_code <= 4'd0;
    end else if (clr) begin
      viol      <= 1'b0;
      viol_code <= 4'd0;
    end else if (!viol && any_hit) begin
      viol      <= 1'b1;
      viol_code <= code_nxt;
    end
  end
endmodule

// File: rtl/ddr_spc_chk.sv
module ddr_spc_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic [2:0]       cmd,
  input logic             viol,
  input logic [3:0]       viol_code,
  input logic             any_hit,
  input logic [CNT_W-1:0] r0_act
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !clr) |=> (viol && $stable(viol_code)));                  // R10
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!viol && viol_code == 4'd0));                              // R10
  AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!viol && !clr && any_hit) |=> (viol && viol_code != 4'd0));        // R10
  AST_FLAG_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    viol == (viol_code != 4'd0));                                       // R13
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd0) |-> !any_hit);                                        // R14
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (r0_act == CMAX && cmd != 3'd1) |=> (r0_act == CMAX));              // R12
endmodule

bind ddr_cmd_spacing_chk ddr_spc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .cmd(cmd), .viol(viol),
  .viol_code(viol_code), .any_hit(any_hit), .r0_act(r_act[0])
);

// File: tb/ddr_cmd_spacing_chk_bench.sv
module ddr_cmd_spacing_chk_bench;
  import ddr_spc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [0:0]  cmd_rank = 1'b0;
  logic [1:0]  cmd_bank = 2'd0;
  logic        cmd_ap = 1'b0;
  logic [1:0]  bl_sel = 2'd1;
  logic        cl_sel = 1'b1;
  logic [16:0] tck_ps, trcd_ps, tras_ps, trp_ps, trrd_ps, trc_ps, trfc_ps, twr_ps;
  logic        viol;
  logic [3:0]  viol_code;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  ddr_cmd_spacing_chk u_ddr_cmd_spacing_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cmd(cmd), .cmd_rank(cmd_rank),
    .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .bl_sel(bl_sel), .cl_sel(cl_sel),
    .tck_ps(tck_ps), .trcd_ps(trcd_ps), .tras_ps(tras_ps), .trp_ps(trp_ps),
    .trrd_ps(trrd_ps), .trc_ps(trc_ps), .trfc_ps(trfc_ps), .twr_ps(twr_ps),
    .viol(viol), .viol_code(viol_code)
  );

  typedef struct packed {
    logic [2:0] c1; logic r1; logic [1:0] b1; logic a1;
    logic [7:0] gap;
    logic [2:0] c2; logic r2; logic [1:0] b2; logic a2;
    logic [3:0] exp;
  } vec_t;

  // 7.5 ns profile, BL4, CL3.5: rcd3 ras6 rp3 rrd2 rc9 rfc10 wpd5 rpd2 wtr4 rtw5
  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{CMD_ACT,1'b0,2'd0,1'b0,8'd2,  CMD_RD, 1'b0,2'd0,1'b0,4'd1},   // R2
    '{CMD_ACT,1'b0,2'd0,1'b0,8'd3,  CMD_RD, 1'b0,2'd0,1'b0,4'd0},   // R2 edge
    '{CMD_ACT,1'b0,2'd1,1'b0,8'd5,  CMD_PRE,1'b0,2'd1,1'b0,4'd2},   // R3
    '{CMD_ACT,1'b0,2'd1,1'b0,8'd6,  CMD_PRE,1'b0,2'd1,1'b0,4'd0},   // R3 edge
    '{CMD_PRE,1'b0,2'd2,1'b0,8'd2,  CMD_ACT,1'b0,2'd2,1'b0,4'd3},   // R4
    '{CMD_PRE,1'b0,2'd2,1'b0,8'd3,  CMD_ACT,1'b0,2'd2,1'b0,4'd0},   // R4 edge
    '{CMD_ACT,1'b0,2'd3,1'b0,8'd8,  CMD_ACT,1'b0,2'd3,1'b0,4'd4},   // R5 and R1 (8.67 -> 9)
    '{CMD_ACT,1'b0,2'd0,1'b0,8'd1,  CMD_ACT,1'b0,2'd1,1'b0,4'd5},   // R5
    '{CMD_ACT,1'b0,2'd0,1'b0,8'd2,  CMD_ACT,1'b0,2'd1,1'b0,4'd0},   // R5 edge
    '{CMD_WR, 1'b0,2'd2,1'b0,8'd4,  CMD_PRE,1'b0,2'd2,1'b0,4'd6},   // R6
    '{CMD_WR, 1'b0,2'd2,1'b0,8'd5,  CMD_PRE,1'b0,2'd2,1'b0,4'd0},   // R6 edge
    '{CMD_RD, 1'b0,2'd3,1'b0,8'd1,  CMD_PRE,1'b0,2'd3,1'b0,4'd7},   // R6
    '{CMD_WR, 1'b1,2'd0,1'b0,8'd3,  CMD_RD, 1'b1,2'd1,1'b0,4'd8},   // R7
    '{CMD_WR, 1'b1,2'd0,1'b0,8'd3,  CMD_RD, 1'b0,2'd1,1'b0,4'd0},   // R7 other rank
    '{CMD_RD, 1'b1,2'd0,1'b0,8'd4,  CMD_WR, 1'b1,2'd2,1'b0,4'd9},   // R7
    '{CMD_MRS,1'b1,2'd0,1'b0,8'd1,  CMD_ACT,1'b1,2'd3,1'b0,4'd10},  // R8
    '{CMD_REF,1'b0,2'd0,1'b0,8'd9,  CMD_REF,1'b0,2'd0,1'b0,4'd11},  // R9
    '{CMD_SRX,1'b1,2'd0,1'b0,8'd9,  CMD_ACT,1'b1,2'd1,1'b0,4'd12},  // R9
    '{CMD_SRX,1'b1,2'd0,1'b0,8'd150,CMD_RD, 1'b1,2'd1,1'b0,4'd13},  // R9
    '{CMD_SRX,1'b1,2'd0,1'b0,8'd12, CMD_RD, 1'b1,2'd1,1'b0,4'd13},  // R9
    '{CMD_RD, 1'b0,2'd1,1'b1,8'd4,  CMD_ACT,1'b0,2'd1,1'b0,4'd3},   // R4 read auto-pre (5)
    '{CMD_RD, 1'b0,2'd1,1'b1,8'd5,  CMD_ACT,1'b0,2'd1,1'b0,4'd0},   // R4 edge
    '{CMD_WR, 1'b0,2'd2,1'b1,8'd8,  CMD_ACT,1'b0,2'd2,1'b0,4'd3},   // R4 write auto-pre (9)
    '{CMD_WR, 1'b0,2'd2,1'b1,8'd9,  CMD_ACT,1'b0,2'd2,1'b0,4'd0}    // R4 edge
  };

  task automatic check(input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, got, exp);
    end
  endtask

  task automatic put(input logic [2:0] c, input logic r, input logic [1:0] b, input logic a);
    cmd = c; cmd_rank = r; cmd_bank = b; cmd_ap = a;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    cmd = 3'd0; cmd_ap = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic fresh();
    clr = 1'b1; idle(1); clr = 1'b0;
    idle(260);
  endtask

  task automatic pair(input string what, input vec_t v);
    fresh();
    put(v.c1, v.r1, v.b1, v.a1);
    idle(int'(v.gap) - 1);
    put(v.c2, v.r2, v.b2, v.a2);
    cmd = 3'd0; cmd_ap = 1'b0;
    check(what, int'(viol_code), int'(v.exp));
  endtask

  task automatic prof75();
    tck_ps = 17'd7500; trcd_ps = 17'd20000; tras_ps = 17'd45000; trp_ps = 17'd20000;
    trrd_ps = 17'd15000; trc_ps = 17'd65000; trfc_ps = 17'd75000; twr_ps = 17'd15000;
  endtask

  task automatic prof60();
    tck_ps = 17'd6000; trcd_ps = 17'd18000; tras_ps = 17'd42000; trp_ps = 17'd18000;
    trrd_ps = 17'd12000; trc_ps = 17'd60000; trfc_ps = 17'd72000; twr_ps = 17'd15000;
  endtask

  initial begin
    prof75();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 reset flag", int'(viol), 0);
    check("R13 reset code", int'(viol_code), 0);
    idle(2);
    check("R13 no history after reset", int'(viol), 0);

    for (int i = 0; i < NV; i++) begin
      pair($sformatf("vector %0d (R2..R9)", i), VEC[i]);
    end

    // R11: same-bank activate breaks RC and RRD, RC wins
    pair("R11 priority", '{CMD_ACT,1'b0,2'd0,1'b0,8'd1,CMD_ACT,1'b0,2'd0,1'b0,4'd4});

    // R10: first violation held through a later one
    fresh();
    put(CMD_ACT, 1'b0, 2'd0, 1'b0);
    idle(1);
    put(CMD_RD, 1'b0, 2'd0, 1'b0);
    put(CMD_PRE, 1'b0, 2'd0, 1'b0);
    idle(2);
    check("R10 held code", int'(viol_code), 1);
    check("R10 held flag", int'(viol), 1);
    clr = 1'b1; idle(1); clr = 1'b0;
    check("R10 cleared", int'(viol), 0);

    // R10: clear in the same cycle as a violation wins
    fresh();
    put(CMD_ACT, 1'b0, 2'd0, 1'b0);
    clr = 1'b1;
    put(CMD_ACT, 1'b0, 2'd0, 1'b0);
    clr = 1'b0;
    idle(2);
    check("R10 clear beats violation", int'(viol), 0);

    // R14: NOPs inside open windows raise nothing
    fresh();
    put(CMD_ACT, 1'b0, 2'd1, 1'b0);
    idle(3);
    check("R14 NOP ignored", int'(viol), 0);

    // R12: gap past counter range must not wrap (261 mod 256 = 5 < 9)
    fresh();
    put(CMD_ACT, 1'b0, 2'd0, 1'b0);
    idle(260);
    put(CMD_ACT, 1'b0, 2'd0, 1'b0);
    idle(1);
    check("R12 saturation", int'(viol_code), 0);

    // R9: read exactly 200 cycles after self-refresh exit is fine
    pair("R9 read exit edge", '{CMD_SRX,1'b1,2'd0,1'b0,8'd200,CMD_RD,1'b1,2'd1,1'b0,4'd0});

    // R3: all-bank precharge checks the bank activated recently
    pair("R3 precharge all", '{CMD_ACT,1'b0,2'd3,1'b0,8'd3,CMD_PRE,1'b0,2'd0,1'b1,4'd2});

    // R6: BL8 read to precharge needs 4
    bl_sel = 2'd2;
    pair("R6 BL8 early", '{CMD_RD,1'b0,2'd3,1'b0,8'd3,CMD_PRE,1'b0,2'd3,1'b0,4'd7});
    pair("R6 BL8 edge",  '{CMD_RD,1'b0,2'd3,1'b0,8'd4,CMD_PRE,1'b0,2'd3,1'b0,4'd0});
    bl_sel = 2'd1;

    // R7: module CL 3 read to write needs 2 + 2
    cl_sel = 1'b0;
    pair("R7 CL3 early", '{CMD_RD,1'b1,2'd0,1'b0,8'd3,CMD_WR,1'b1,2'd1,1'b0,4'd9});
    pair("R7 CL3 edge",  '{CMD_RD,1'b1,2'd0,1'b0,8'd4,CMD_WR,1'b1,2'd1,1'b0,4'd0});
    cl_sel = 1'b1;

    // R1: 6 ns profile, tWR 2.5 -> 3: WPD 6, DAL 2+2+3+3 = 10
    prof60();
    pair("R1 write-precharge early", '{CMD_WR,1'b0,2'd2,1'b0,8'd5,CMD_PRE,1'b0,2'd2,1'b0,4'd6});
    pair("R1 write-precharge edge",  '{CMD_WR,1'b0,2'd2,1'b0,8'd6,CMD_PRE,1'b0,2'd2,1'b0,4'd0});
    pair("R1 auto-pre write early",  '{CMD_WR,1'b0,2'd1,1'b1,8'd9,CMD_ACT,1'b0,2'd1,1'b0,4'd3});
    pair("R1 auto-pre write edge",   '{CMD_WR,1'b0,2'd1,1'b1,8'd10,CMD_ACT,1'b0,2'd1,1'b0,4'd0});

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule